// File: doc/BRIEF.md
# Two-Stage Master Serial Clock Divider

This block derives the master bit clock of a synchronous serial port from the peripheral bus clock. A first stage divides the bus clock by an even ratio that is set by an 8-bit prescale value. The prescale value's bit 0 takes no part in the ratio. A second stage counts first-stage ticks and divides again by an 8-bit rate value plus one. A toggle stage flips the serial clock each time the chain ends a half-period. The result is a serial clock of exactly 50 % duty at `f_clk / (P_even * (1 + S))`, where `P_even` is the even part of the prescale value.

Alongside the clock, the block produces one-cycle strobes that mark each rising and each falling transition, so that shift logic clocked by the bus clock can act on serial edges without sampling the divided clock. While the enable is low, the clock rests low and both counters keep loading the current settings. New settings are taken only at a half-period boundary, so the output never shows a runt pulse.

Top module: `serclk_gen`

## Requirements
- R1: Each half-period of `sclk_o` lasts exactly H = E * (S + 1) bus clock cycles. E is `presc_i[7:1]` read as an unsigned number (minimum 1), and S is `rate_i`. The full period is therefore `presc_i` rounded down to even, times (S + 1).
- R2: Bit 0 of `presc_i` has no effect on timing. For example, prescale values 6 and 7 give identical half-periods.
- R3: When `presc_i[7:1]` is zero (prescale values 0 or 1), the first stage behaves as a divide-by-2, so H = S + 1.
- R4: The rate value spans the full second-stage range. A value of 255 gives a factor of 256.
- R5: While `en_i` is low, `sclk_o`, `rise_o` and `fall_o` are all 0 from the cycle after `en_i` is sampled low. Dropping `en_i` during a high phase returns `sclk_o` to 0 without a `fall_o` strobe.
- R6: Counting the first rising bus clock edge that samples `en_i` high as edge 1, the first transition of `sclk_o` is a rise, registered at edge H.
- R7: `rise_o` is 1 for exactly the one cycle in which `sclk_o` has just gone from 0 to 1. `fall_o` is 1 for exactly the one cycle in which it has just gone from 1 to 0. The two are never high together.
- R8: The high and low phases of `sclk_o` have equal length, so the duty cycle is 50 %.
- R9: Changing `presc_i` or `rate_i` while enabled does not alter the half-period in progress. The new values set the length of the next half-period.
- R10: After reset, `sclk_o`, `rise_o` and `fall_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Runs the divider when high; idles it low when low |
| presc_i | input | 8 | First-stage prescale value; bit 0 unused |
| rate_i | input | 8 | Second-stage rate value; divides by value + 1 |
| sclk_o | output | 1 | Divided serial clock |
| rise_o | output | 1 | One-cycle strobe on a rising serial clock transition |
| fall_o | output | 1 | One-cycle strobe on a falling serial clock transition |

## Verification
The bench targets the corners where a divider usually fails:
- A half-period of one bus cycle (prescale 0, 1 or 2 with rate 0). An off-by-one reload would stall the clock or double the half-period there.
- Odd prescale values. A design that used bit 0 would stretch these half-periods by a fraction of the expected length.
- A rate of 255. A design that lost the counter's top bit would wrap to a short count.
- A settings change in mid-phase. A design that reloaded from the live inputs would cut the running half-period short.
- Dropping the enable during a high phase. A design that emitted a stray fall strobe on disable, or left the clock high, would show up here.

Random settings check the duty cycle and the strobe alignment over many ratios.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    // Registered state of the output toggle stage
    typedef struct packed {
        logic sclk;
        logic rise;
        logic fall;
    } edge_state_t;

    localparam edge_state_t EDGE_IDLE = '{sclk: 1'b0, rise: 1'b0, fall: 1'b0};

endpackage

// File: rtl/serclk_prescale.sv
// First stage: even divisor. Counts E bus cycles per tick, where E is the
// prescale value with its low bit dropped (zero treated as one).
module serclk_prescale #(
    parameter int PW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          reload_i,
    input  logic [PW-1:0] presc_i,
    output logic          tick_o
);
    localparam int CW = PW - 1;

    typedef struct packed {
        logic [CW-1:0] lim;
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [CW-1:0] eff_lim;

    always_comb begin
        eff_lim = presc_i[PW-1:1];
        if (eff_lim == '0) begin
            eff_lim = CW'(1);
        end
    end

    assign tick_o = en_i && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (!en_i || reload_i) begin
            st_d.lim = eff_lim;
            st_d.cnt = eff_lim - CW'(1);
        end else if (tick_o) begin
            st_d.cnt = st_q.lim - CW'(1);
        end else begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{lim: CW'(1), cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_CNT_BELOW_LIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < st_q.lim);                                            // R1
    AST_PRE_LIM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lim != '0);                                                 // R3
    AST_PRE_LIM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i) && !$past(reload_i)) |-> $stable(st_q.lim)); // R9

endmodule

// File: rtl/serclk_rate.sv
// Second stage: counts first-stage ticks, ends a half-period after rate+1 ticks.
module serclk_rate #(
    parameter int RW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [RW-1:0] rate_i,
    output logic          term_o
);
    logic [RW-1:0] cnt_d, cnt_q;

    assign term_o = tick_i && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || term_o) begin
            cnt_d = rate_i;
        end else if (tick_i) begin
            cnt_d = cnt_q - RW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_RATE_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i) && !$past(tick_i)) |-> $stable(cnt_q));    // R1

endmodule

// File: rtl/serclk_toggle.sv
// Output stage: flips the serial clock at each half-period end, with strobes.
module serclk_toggle
    import serclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic term_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (!en_i) begin
            st_d = EDGE_IDLE;
        end else if (term_i) begin
            st_d.sclk = !st_q.sclk;
            st_d.rise = !st_q.sclk;
            st_d.fall = st_q.sclk;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= EDGE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = st_q.sclk;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    AST_RISE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (sclk_o && !$past(sclk_o)));                         // R7
    AST_FALL_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> (!sclk_o && $past(sclk_o)));                         // R7
    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));                                           // R7
    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i) |-> (!sclk_o && !rise_o && !fall_o));              // R5

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen #(
    parameter int PW = 8,
    parameter int RW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [PW-1:0] presc_i,
    input  logic [RW-1:0] rate_i,
    output logic          sclk_o,
    output logic          rise_o,
    output logic          fall_o
);
    logic pre_tick;
    logic half_end;

    serclk_prescale #(.PW(PW)) u_prescale (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .reload_i (half_end),
        .presc_i  (presc_i),
        .tick_o   (pre_tick)
    );

    serclk_rate #(.RW(RW)) u_rate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .tick_i (pre_tick),
        .rate_i (rate_i),
        .term_o (half_end)
    );

    serclk_toggle u_toggle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .term_i (half_end),
        .sclk_o (sclk_o),
        .rise_o (rise_o),
        .fall_o (fall_o)
    );

    AST_TOGGLE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && $past(en_i) && (sclk_o != $past(sclk_o))) |-> $past(pre_tick)); // R1

endmodule

// File: tb/serclk_gen_bench.sv
module serclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] presc = 8'd0;
    logic [7:0] rate = 8'd0;
    logic       sclk, rise, fall;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = !clk;

    serclk_gen u_serclk_gen (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .en_i    (en),
        .presc_i (presc),
        .rate_i  (rate),
        .sclk_o  (sclk),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    function automatic int half_len(input logic [7:0] p, input logic [7:0] s);
        int e;
        e = int'(p) / 2;
        if (e == 0) e = 1;
        return e * (int'(s) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(sclk == 1'b0, {req, " sclk idle"}, int'(sclk), 0);
        check(rise == 1'b0 && fall == 1'b0, {req, " strobes idle"}, int'({rise, fall}), 0);
    endtask

    // Measures `halves` transitions; optional mid-phase settings change at cycle chg_at.
    task automatic run_cfg(input logic [7:0] p, input logic [7:0] s, input int halves,
                           input string req, input int chg_at,
                           input logic [7:0] p2, input logic [7:0] s2);
        int  h, cnt, last, seen;
        logic prev;
        en = 1'b0;
        presc = p;
        rate = s;
        repeat (3) begin
            @(negedge clk);
            check_idle("R5");
        end
        en = 1'b1;
        h = half_len(p, s);
        cnt = 0; last = 0; seen = 0; prev = 1'b0;
        while (seen < halves) begin
            @(negedge clk);
            cnt++;
            check(rise == (sclk && !prev), "R7 rise", int'(rise), int'(sclk && !prev));
            check(fall == (!sclk && prev), "R7 fall", int'(fall), int'(!sclk && prev));
            if (sclk != prev) begin
                if (seen == 0) begin
                    check(sclk == 1'b1, "R6 first edge rises", int'(sclk), 1);
                end
                check(cnt - last == h, {req, " half-period R1 R8"}, cnt - last, h);
                seen++;
                last = cnt;
                if (seen == 1 && chg_at < 0) h = h;
                if (chg_at >= 0 && seen == 1) h = half_len(p2, s2);
            end else if (cnt - last > h) begin
                check(1'b0, {req, " clock stalled R1"}, cnt - last, h);
                break;
            end
            if (cnt == chg_at) begin
                presc = p2;
                rate = s2;
            end
            prev = sclk;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_idle("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R10");

        // R3: zero-valued upper prescale bits act as divide-by-2
        run_cfg(8'd0, 8'd0, 6, "R3", -1, 8'd0, 8'd0);
        run_cfg(8'd1, 8'd3, 4, "R3", -1, 8'd0, 8'd0);
        run_cfg(8'd2, 8'd0, 4, "R1", -1, 8'd0, 8'd0);
        // R2: low bit ignored
        run_cfg(8'd7, 8'd2, 4, "R2", -1, 8'd0, 8'd0);
        run_cfg(8'd6, 8'd2, 4, "R2", -1, 8'd0, 8'd0);
        run_cfg(8'd255, 8'd0, 4, "R2", -1, 8'd0, 8'd0);
        // R4: maximum rate factor of 256
        run_cfg(8'd2, 8'd255, 3, "R4", -1, 8'd0, 8'd0);
        // R9: mid-phase change must not disturb the running half-period
        run_cfg(8'd4, 8'd1, 3, "R9", 2, 8'd10, 8'd0);
        run_cfg(8'd20, 8'd3, 3, "R9", 5, 8'd2, 8'd0);

        // R5: drop enable during a high phase
        run_cfg(8'd8, 8'd1, 1, "R1", -1, 8'd0, 8'd0);
        check(sclk == 1'b1, "R5 precondition high", int'(sclk), 1);
        en = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R5 disable forces low", int'(sclk), 0);
        check(fall == 1'b0, "R5 no fall strobe on disable", int'(fall), 0);

        // Random settings
        for (int i = 0; i < 24; i++) begin
            logic [7:0] rp, rs;
            rp = 8'($urandom % 64);
            rs = 8'($urandom % 8);
            run_cfg(rp, rs, 4, "R8 random", -1, 8'd0, 8'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule